// File: doc/BRIEF.md
# Scratch-Indirect Load/Store Slot

This block is one memory-access slot of a wide-issue datapath. It carries words between an external scratch register file and an external word-addressed data memory. An instruction never carries a memory address itself. It names a scratch entry, and the value held there is used as the memory address. Five operations are handled: an immediate constant written to scratch, a one-word load, an eight-word load, a one-word store and an eight-word store. An eight-word access always covers consecutive memory words starting at the fetched address.

The slot takes one instruction per cycle. In the issue cycle it reads the pointer entry and the source vector from scratch, checks the access span against the memory size, and drives the memory port. That port is eight words wide and has one write enable per word. Stores are written at the end of the issue cycle. Load data and constants reach the scratch write port one cycle after issue, together with a done strobe. A scratch write lands at the end of its cycle, so any instruction issued in that cycle still reads the older value.

Top module: `ind_ldst_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ld_done`, `oor_err` and `wb_lane_en` are 0. With `issue_valid` low, `mem_en` is 0.
- R2: Opcode 1 (constant) writes `issue_imm` into scratch entry `issue_dst` one cycle after issue. Only lane 0 of `wb_lane_en` is set, and `ld_done` pulses in the same cycle.
- R3: Opcode 2 (one-word load) reads memory word A, where A is the value held in scratch entry `issue_ptr`. Lane 0 of the scratch write port then carries that word to entry `issue_dst`, one cycle after issue.
- R4: Opcode 3 (eight-word load) copies memory words A through A+7 into scratch entries `issue_dst` through `issue_dst`+7, lane i carrying word A+i. The write happens one cycle after issue, with all eight lanes enabled.
- R5: Opcode 4 (one-word store) writes scratch entry `issue_src` to memory word A at the end of the issue cycle. Only `mem_we` bit 0 is set, so the seven neighbouring words stay unchanged.
- R6: Opcode 5 (eight-word store) writes scratch entries `issue_src`+i to memory words A+i, for i from 0 to 7, at the end of the issue cycle. All eight bits of `mem_we` are set.
- R7: A is the full-width value of the named pointer entry, read in the issue cycle. `mem_base` carries A whenever `mem_en` is high.
- R8: A one-word access is in range when A is no greater than the last memory word. An eight-word access is in range when A+7 is no greater than it. For an out-of-range access, `mem_en` stays 0 and no scratch write or done strobe follows. `oor_err` pulses for one cycle, one cycle after issue.
- R9: `ld_done` pulses exactly one cycle after an in-range load or a constant, and never for a store. `ld_done` and `oor_err` are never high together.
- R10: An instruction issued in the cycle a writeback is driven reads the pre-writeback scratch values. A store issued then completes in that same cycle. A load issued right after a store to the same word sees the stored value.
- R11: Opcodes 0, 6 and 7, and any cycle with `issue_valid` low, cause no memory access, no scratch write, no done strobe and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Instruction present this cycle |
| issue_op | input | 3 | Opcode (0 none, 1 constant, 2/3 load one/eight, 4/5 store one/eight) |
| issue_dst | input | SCR_AW | Destination scratch entry for loads and constants |
| issue_ptr | input | SCR_AW | Scratch entry holding the memory address |
| issue_src | input | SCR_AW | First source scratch entry for stores |
| issue_imm | input | DATA_W | Immediate value for the constant operation |
| ptr_raddr | output | SCR_AW | Scratch read address for the pointer |
| ptr_rdata | input | DATA_W | Scratch pointer read data |
| vec_raddr | output | SCR_AW | Scratch read base for store data (lane i = base+i) |
| vec_rdata | input | LANES*DATA_W | Scratch store data, lane i in bits i*DATA_W upward |
| wb_lane_en | output | LANES | Per-lane scratch write enables |
| wb_base | output | SCR_AW | Scratch write base (lane i goes to base+i) |
| wb_data | output | LANES*DATA_W | Scratch write data |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | LANES | Per-word write enables (word base+i) |
| mem_base | output | MEM_AW | First memory word of the access |
| mem_wdata | output | LANES*DATA_W | Store data |
| mem_rdata | input | LANES*DATA_W | Read data, one cycle after `mem_en` |
| ld_done | output | 1 | Scratch writeback strobe |
| oor_err | output | 1 | Out-of-range access strobe |

## Verification
Two things can fall into the same cycle: the scratch writeback of a load or constant issued one cycle earlier, and a store issued now that reads scratch and writes memory. The bench provokes this by issuing an eight-word load and then, in the next cycle, an eight-word store over the same scratch and memory ranges. It also runs a constant followed at once by a one-word store of its destination entry. These pairs are correct only if the data ends up swapped: memory gets the old scratch contents and scratch gets the old memory contents. The reverse order, a store followed at once by a load of the same word, must return the freshly stored value.

// File: rtl/ildst_pkg.sv
package ildst_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_IMM  = 3'd1,
    OP_RD1  = 3'd2,
    OP_RD8  = 3'd3,
    OP_WR1  = 3'd4,
    OP_WR8  = 3'd5
  } ldst_op_e;

  // number of words an access touches
  function automatic int unsigned access_span(input logic vec, input int unsigned lanes);
    return vec ? lanes : 32'd1;
  endfunction

  // true when words base .. base+span-1 all lie below 'words'
  function automatic logic span_fits(input logic [63:0] base, input int unsigned span,
                                     input int unsigned words);
    logic [64:0] last;
    last = {1'b0, base} + 65'(span) - 65'd1;
    return 65'(words) > last;
  endfunction

endpackage

// File: rtl/ildst_decode.sv
module ildst_decode
  import ildst_pkg::*;
(
  input  logic       op_valid,
  input  logic [2:0] op_code,
  output logic       is_imm,
  output logic       is_load,
  output logic       is_store,
  output logic       is_vec
);

  always_comb begin
    is_imm   = 1'b0;
    is_load  = 1'b0;
    is_store = 1'b0;
    is_vec   = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_IMM: is_imm = 1'b1;
        OP_RD1: is_load = 1'b1;
        OP_RD8: begin is_load = 1'b1; is_vec = 1'b1; end
        OP_WR1: is_store = 1'b1;
        OP_WR8: begin is_store = 1'b1; is_vec = 1'b1; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ildst_range.sv
module ildst_range
  import ildst_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MEM_AW = 10,
  parameter int unsigned LANES  = 8
) (
  input  logic [DATA_W-1:0] base,
  input  logic              is_vec,
  output logic              fits
);

  localparam int unsigned MEM_WORDS = 1 << MEM_AW;

  assign fits = span_fits(64'(base), access_span(is_vec, LANES), MEM_WORDS);

endmodule

// File: rtl/ildst_wb.sv
module ildst_wb #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SCR_AW = 7,
  parameter int unsigned LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take_wb,
  input  logic                    from_mem,
  input  logic                    is_vec,
  input  logic                    fault,
  input  logic [SCR_AW-1:0]       dst,
  input  logic [DATA_W-1:0]       imm,
  input  logic [LANES*DATA_W-1:0] mem_rdata,
  output logic [LANES-1:0]        lane_en,
  output logic [SCR_AW-1:0]       base,
  output logic [LANES*DATA_W-1:0] data,
  output logic                    done,
  output logic                    err
);

  logic              wb_v, wb_mem, wb_vec, err_q;
  logic [SCR_AW-1:0] wb_dst;
  logic [DATA_W-1:0] wb_imm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_v   <= 1'b0;
      wb_mem <= 1'b0;
      wb_vec <= 1'b0;
      err_q  <= 1'b0;
      wb_dst <= '0;
      wb_imm <= '0;
    end else begin
      wb_v   <= take_wb;
      wb_mem <= from_mem;
      wb_vec <= is_vec;
      err_q  <= fault;
      if (take_wb) begin
        wb_dst <= dst;
        wb_imm <= imm;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_head
      assign data[DATA_W-1:0] = wb_mem ? mem_rdata[DATA_W-1:0] : wb_imm;
      assign lane_en[0]       = wb_v;
    end else begin : g_tail
      assign data[g*DATA_W +: DATA_W] = wb_mem ? mem_rdata[g*DATA_W +: DATA_W] : '0;
      assign lane_en[g]               = wb_v & wb_vec;
    end
  end

  assign base = wb_dst;
  assign done = wb_v;
  assign err  = err_q;

endmodule

// File: rtl/ind_ldst_unit.sv
module ind_ldst_unit #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SCR_AW = 7,
  parameter int unsigned MEM_AW = 10,
  parameter int unsigned LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_valid,
  input  logic [2:0]              issue_op,
  input  logic [SCR_AW-1:0]       issue_dst,
  input  logic [SCR_AW-1:0]       issue_ptr,
  input  logic [SCR_AW-1:0]       issue_src,
  input  logic [DATA_W-1:0]       issue_imm,
  output logic [SCR_AW-1:0]       ptr_raddr,
  input  logic [DATA_W-1:0]       ptr_rdata,
  output logic [SCR_AW-1:0]       vec_raddr,
  input  logic [LANES*DATA_W-1:0] vec_rdata,
  output logic [LANES-1:0]        wb_lane_en,
  output logic [SCR_AW-1:0]       wb_base,
  output logic [LANES*DATA_W-1:0] wb_data,
  output logic                    mem_en,
  output logic [LANES-1:0]        mem_we,
  output logic [MEM_AW-1:0]       mem_base,
  output logic [LANES*DATA_W-1:0] mem_wdata,
  input  logic [LANES*DATA_W-1:0] mem_rdata,
  output logic                    ld_done,
  output logic                    oor_err
);

  // decoded instruction
  logic is_imm, is_load, is_store, is_vec;
  // named events, also watched by the checker
  logic fits, acc_go, acc_fault, take_wb;
  logic [LANES-1:0] lane_mask;

  ildst_decode u_dec (
    .op_valid (issue_valid),
    .op_code  (issue_op),
    .is_imm   (is_imm),
    .is_load  (is_load),
    .is_store (is_store),
    .is_vec   (is_vec)
  );

  ildst_range #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .LANES(LANES)) u_rng (
    .base   (ptr_rdata),
    .is_vec (is_vec),
    .fits   (fits)
  );

  assign acc_go    = (is_load | is_store) & fits;
  assign acc_fault = (is_load | is_store) & ~fits;
  assign take_wb   = is_imm | (is_load & fits);

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    if (g == 0) begin : g_first
      assign lane_mask[0] = 1'b1;
    end else begin : g_rest
      assign lane_mask[g] = is_vec;
    end
  end

  // scratch read side
  assign ptr_raddr = issue_ptr;
  assign vec_raddr = issue_src;

  // memory port
  assign mem_en    = acc_go;
  assign mem_we    = (acc_go & is_store) ? lane_mask : '0;
  assign mem_base  = ptr_rdata[MEM_AW-1:0];
  assign mem_wdata = vec_rdata;

  ildst_wb #(.DATA_W(DATA_W), .SCR_AW(SCR_AW), .LANES(LANES)) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_wb   (take_wb),
    .from_mem  (is_load),
    .is_vec    (is_vec),
    .fault     (acc_fault),
    .dst       (issue_dst),
    .imm       (issue_imm),
    .mem_rdata (mem_rdata),
    .lane_en   (wb_lane_en),
    .base      (wb_base),
    .data      (wb_data),
    .done      (ld_done),
    .err       (oor_err)
  );

endmodule

// File: rtl/ildst_chk.sv
module ildst_chk #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned MEM_AW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              mem_en,
  input logic [LANES-1:0]  mem_we,
  input logic [MEM_AW-1:0] mem_base,
  input logic [LANES-1:0]  wb_lane_en,
  input logic              ld_done,
  input logic              oor_err,
  input logic              acc_fault
);

  localparam logic [MEM_AW:0] VEC_LAST = (MEM_AW+1)'((1 << MEM_AW) - LANES);

  AST_WE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && (mem_we != '0) && !(&mem_we) |-> (mem_we == LANES'(1))); // R5

  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && (&mem_we) |-> ({1'b0, mem_base} <= VEC_LAST)); // R8

  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> !mem_en); // R8

  AST_FAULT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |=> (oor_err && !ld_done)); // R8

  AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> $past(issue_valid)); // R9

  AST_DONE_ERR_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_done && oor_err)); // R9

  AST_WB_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (|wb_lane_en) |-> ld_done); // R9

  AST_DONE_HAS_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> wb_lane_en[0]); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> !mem_en); // R11

endmodule

bind ind_ldst_unit ildst_chk #(.LANES(LANES), .MEM_AW(MEM_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_base    (mem_base),
  .wb_lane_en  (wb_lane_en),
  .ld_done     (ld_done),
  .oor_err     (oor_err),
  .acc_fault   (acc_fault)
);

// File: tb/tb_ind_ldst_unit.sv
`timescale 1ns/1ps
module tb_ind_ldst_unit;

  localparam int DW = 16;
  localparam int SA = 5;
  localparam int MA = 5;
  localparam int LN = 8;
  localparam int NS = 1 << SA;
  localparam int NM = 1 << MA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              issue_valid = 1'b0;
  logic [2:0]        issue_op = '0;
  logic [SA-1:0]     issue_dst = '0, issue_ptr = '0, issue_src = '0;
  logic [DW-1:0]     issue_imm = '0;
  logic [SA-1:0]     ptr_raddr, vec_raddr, wb_base;
  logic [DW-1:0]     ptr_rdata;
  logic [LN*DW-1:0]  vec_rdata, wb_data, mem_wdata, mem_rdata;
  logic [LN-1:0]     wb_lane_en, mem_we;
  logic              mem_en, ld_done, oor_err;
  logic [MA-1:0]     mem_base;

  ind_ldst_unit #(.DATA_W(DW), .SCR_AW(SA), .MEM_AW(MA), .LANES(LN)) dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_dst(issue_dst), .issue_ptr(issue_ptr), .issue_src(issue_src),
    .issue_imm(issue_imm), .ptr_raddr(ptr_raddr), .ptr_rdata(ptr_rdata),
    .vec_raddr(vec_raddr), .vec_rdata(vec_rdata), .wb_lane_en(wb_lane_en),
    .wb_base(wb_base), .wb_data(wb_data), .mem_en(mem_en), .mem_we(mem_we),
    .mem_base(mem_base), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_done(ld_done), .oor_err(oor_err)
  );

  // bench models of the scratch file and the memory, plus golden copies
  logic [DW-1:0] m_scr [NS];
  logic [DW-1:0] m_mem [NM];
  logic [DW-1:0] g_scr [NS];
  logic [DW-1:0] g_mem [NM];

  function automatic logic [DW-1:0] scr_init(input int i);
    return DW'(i * 16'h0101) ^ 16'h3C00;
  endfunction
  function automatic logic [DW-1:0] mem_init(input int i);
    return DW'(16'h5000 + i * 7);
  endfunction

  assign ptr_rdata = m_scr[ptr_raddr];
  always_comb begin
    for (int i = 0; i < LN; i++) vec_rdata[i*DW +: DW] = m_scr[(int'(vec_raddr) + i) % NS];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) m_scr[i] <= scr_init(i);
      for (int i = 0; i < NM; i++) m_mem[i] <= mem_init(i);
      mem_rdata <= '0;
    end else begin
      if (mem_en) begin
        for (int i = 0; i < LN; i++) begin
          if (int'(mem_base) + i < NM) begin
            if (mem_we[i]) m_mem[int'(mem_base) + i] <= mem_wdata[i*DW +: DW];
            mem_rdata[i*DW +: DW] <= m_mem[int'(mem_base) + i];
          end else begin
            mem_rdata[i*DW +: DW] <= '0;
          end
        end
      end
      for (int i = 0; i < LN; i++)
        if (wb_lane_en[i]) m_scr[(int'(wb_base) + i) % NS] <= wb_data[i*DW +: DW];
    end
  end

  int n_run = 0, n_fail = 0, cyc = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_arrays(input string req);
    int bs, bm;
    bs = -1; bm = -1;
    for (int i = 0; i < NS; i++) if (m_scr[i] !== g_scr[i] && bs < 0) bs = i;
    for (int i = 0; i < NM; i++) if (m_mem[i] !== g_mem[i] && bm < 0) bm = i;
    if (bs < 0) chk(req, "scratch", 0, 0);
    else chk(req, $sformatf("scratch[%0d]", bs), int'(m_scr[bs]), int'(g_scr[bs]));
    if (bm < 0) chk(req, "memory", 0, 0);
    else chk(req, $sformatf("memory[%0d]", bm), int'(m_mem[bm]), int'(g_mem[bm]));
  endtask

  // issue one instruction in isolation and check all three cycles around it
  task automatic do_op(input bit v, input logic [2:0] code, input logic [SA-1:0] dst,
                       input logic [SA-1:0] ptr, input logic [SA-1:0] src,
                       input logic [DW-1:0] imm, input string req);
    bit cst, ld, st, vec, ok, done_x;
    int span, a;
    logic [LN-1:0] we_x, wb_x;
    cst  = v && code == 3'd1;
    ld   = v && (code == 3'd2 || code == 3'd3);
    st   = v && (code == 3'd4 || code == 3'd5);
    vec  = code == 3'd3 || code == 3'd5;
    span = vec ? 8 : 1;
    a    = int'(g_scr[ptr]);
    ok   = (a + span) <= NM;
    @(negedge clk);
    issue_valid = v; issue_op = code; issue_dst = dst;
    issue_ptr = ptr; issue_src = src; issue_imm = imm;
    #1;
    chk(req, "mem_en", int'(mem_en), int'((ld || st) && ok));
    we_x = (st && ok) ? (vec ? 8'hFF : 8'h01) : 8'h00;
    chk(req, "mem_we", int'(mem_we), int'(we_x));
    if ((ld || st) && ok) chk("R7", "mem_base", int'(mem_base), a);
    if (st && ok) for (int i = 0; i < span; i++) g_mem[a + i] = g_scr[(int'(src) + i) % NS];
    if (ld && ok) for (int i = 0; i < span; i++) g_scr[(int'(dst) + i) % NS] = g_mem[a + i];
    if (cst) g_scr[dst] = imm;
    @(negedge clk);
    issue_valid = 1'b0; issue_op = 3'd0;
    #1;
    done_x = cst || (ld && ok);
    chk(req, "ld_done", int'(ld_done), int'(done_x));
    chk(req, "oor_err", int'(oor_err), int'((ld || st) && !ok));
    wb_x = done_x ? ((ld && vec) ? 8'hFF : 8'h01) : 8'h00;
    chk(req, "wb_lane_en", int'(wb_lane_en), int'(wb_x));
    @(negedge clk);
    cmp_arrays(req);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] t_s [LN];
    logic [DW-1:0] t_m [LN];
    logic [DW-1:0] old;
    logic [DW-1:0] extra [3];
    extra[0] = 16'hFFFF; extra[1] = 16'h8001; extra[2] = 16'h0100;
    for (int i = 0; i < NS; i++) g_scr[i] = scr_init(i);
    for (int i = 0; i < NM; i++) g_mem[i] = mem_init(i);

    repeat (3) @(negedge clk);
    chk("R1", "ld_done in reset", int'(ld_done), 0);
    chk("R1", "oor_err in reset", int'(oor_err), 0);
    chk("R1", "wb_lane_en in reset", int'(wb_lane_en), 0);
    chk("R1", "mem_en in reset", int'(mem_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ld_done after reset", int'(ld_done), 0);
    chk("R1", "wb_lane_en after reset", int'(wb_lane_en), 0);
    cmp_arrays("R1");

    // constants into every scratch entry
    for (int d = 0; d < NS; d++)
      do_op(1'b1, 3'd1, SA'(d), 5'd0, 5'd0, DW'(d * 1111) ^ 16'hA5A5, "R2");

    // address sweep for all four memory forms, through two pointer entries
    for (int k = 0; k < 39; k++) begin
      logic [DW-1:0] av;
      logic [SA-1:0] p, r;
      av = (k < 36) ? DW'(k) : extra[k - 36];
      p  = (k % 2 == 0) ? 5'd1 : 5'd3;
      r  = SA'(8 + (k % 3) * 8);
      do_op(1'b1, 3'd1, p, 5'd0, 5'd0, av, "R2");
      do_op(1'b1, 3'd2, r, p, 5'd0, 16'h0, (av < NM) ? "R3" : "R8");
      do_op(1'b1, 3'd1, p, 5'd0, 5'd0, av, "R7");
      do_op(1'b1, 3'd3, r, p, 5'd0, 16'h0, (av <= NM - 8) ? "R4" : "R8");
      do_op(1'b1, 3'd1, p, 5'd0, 5'd0, av, "R7");
      do_op(1'b1, 3'd4, 5'd0, p, SA'(r + 5), 16'h0, (av < NM) ? "R5" : "R8");
      do_op(1'b1, 3'd1, p, 5'd0, 5'd0, av, "R7");
      do_op(1'b1, 3'd5, 5'd0, p, r, 16'h0, (av <= NM - 8) ? "R6" : "R8");
    end

    // ignored codes and idle cycles
    do_op(1'b1, 3'd1, 5'd2, 5'd0, 5'd0, 16'd4, "R2");
    do_op(1'b1, 3'd0, 5'd8, 5'd2, 5'd8, 16'h1234, "R11");
    do_op(1'b1, 3'd6, 5'd8, 5'd2, 5'd8, 16'h1234, "R11");
    do_op(1'b1, 3'd7, 5'd8, 5'd2, 5'd8, 16'h1234, "R11");
    do_op(1'b0, 3'd3, 5'd8, 5'd2, 5'd8, 16'h1234, "R11");
    do_op(1'b0, 3'd5, 5'd8, 5'd2, 5'd8, 16'h1234, "R11");
    do_op(1'b0, 3'd1, 5'd9, 5'd2, 5'd8, 16'h1234, "R11");

    // back to back: eight-word load then eight-word store over the same ranges
    do_op(1'b1, 3'd1, 5'd2, 5'd0, 5'd0, 16'd10, "R2");
    for (int i = 0; i < LN; i++) begin t_s[i] = g_mem[10 + i]; t_m[i] = g_scr[8 + i]; end
    @(negedge clk);
    issue_valid = 1'b1; issue_op = 3'd3; issue_dst = 5'd8; issue_ptr = 5'd2;
    @(negedge clk);
    issue_op = 3'd5; issue_src = 5'd8;
    #1;
    chk("R10", "ld_done with store", int'(ld_done), 1);
    chk("R10", "wb_lane_en with store", int'(wb_lane_en), 8'hFF);
    chk("R10", "mem_we with writeback", int'(mem_we), 8'hFF);
    @(negedge clk);
    issue_valid = 1'b0; issue_op = 3'd0;
    @(negedge clk);
    for (int i = 0; i < LN; i++) begin g_scr[8 + i] = t_s[i]; g_mem[10 + i] = t_m[i]; end
    cmp_arrays("R10");

    // constant then one-word store of that entry in the next cycle
    old = g_scr[20];
    @(negedge clk);
    issue_valid = 1'b1; issue_op = 3'd1; issue_dst = 5'd20; issue_imm = 16'hBEEF;
    @(negedge clk);
    issue_op = 3'd4; issue_src = 5'd20; issue_ptr = 5'd2;
    #1;
    chk("R10", "ld_done with scalar store", int'(ld_done), 1);
    chk("R10", "mem_we scalar", int'(mem_we), 8'h01);
    @(negedge clk);
    issue_valid = 1'b0; issue_op = 3'd0;
    @(negedge clk);
    g_scr[20] = 16'hBEEF; g_mem[10] = old;
    cmp_arrays("R10");

    // store then load of the same word in the next cycle
    @(negedge clk);
    issue_valid = 1'b1; issue_op = 3'd4; issue_src = 5'd24; issue_ptr = 5'd2;
    @(negedge clk);
    issue_op = 3'd2; issue_dst = 5'd16;
    @(negedge clk);
    issue_valid = 1'b0; issue_op = 3'd0;
    #1;
    chk("R10", "load after store done", int'(ld_done), 1);
    chk("R10", "load after store data", int'(wb_data[DW-1:0]), int'(g_scr[24]));
    @(negedge clk);
    g_mem[10] = g_scr[24]; g_scr[16] = g_scr[24];
    cmp_arrays("R10");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule